// File: doc/BRIEF.md
# Phase-Slot Coherent Averager

This block averages two demodulated channels, in-phase and quadrature, by adding each incoming sample into a bin picked by its phase slot within the reference period. A period holds 30 slots. Bins keep summing across 7 consecutive periods, and that run of periods makes up one frame. When a frame closes, its bins are frozen in one of two banks. Acquisition carries on at once in the other bank, which is cleared at the same moment.

A sequential reducer then walks the 30 frozen bins of each channel one per clock. It adds them up and drops the single largest and the single smallest bin. The undivided sum of the remaining 28 bins is presented as the frame result, and a one-clock strobe marks it. Period starts are marked by a sync pulse that comes with the slot-0 sample. Nothing is accumulated until the first such pulse after reset, so bins always line up with the reference phase.

Top module: `sync_slot_avg`

## Requirements
- R1: While reset is asserted, and until the first result, `result_valid` is 0 and both result ports are 0.
- R2: Samples that arrive before the first accepted sync after reset (`sample_valid` and `cycle_sync` both 1) are not accumulated into any result.
- R3: Each accepted sample is sign-extended and added into bin `slot_index` of its own channel. I and Q are accumulated in parallel and never mix.
- R4: A sample whose `slot_index` is 30 or 31 is discarded.
- R5: Each accepted sync starts a new period. The sync that begins the eighth period since the frame began closes the frame. Its own sample is the first one of the next frame, and it is written into a freshly cleared bank, so nothing carries over between frames.
- R6: Per channel, the result equals the sum of all 30 bins minus the largest bin minus the smallest bin, as a signed 37-bit value.
- R7: `result_valid` is high for exactly one clock, 30 clocks after the closing sync edge. The result ports hold their value between strobes.
- R8: Samples arriving while the reducer works on the previous frame are accumulated without loss.
- R9: When `sample_valid` is 0, the data inputs and `cycle_sync` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Sample strobe |
| samp_i | input | 24 | In-phase sample, two's complement |
| samp_q | input | 24 | Quadrature sample, two's complement |
| slot_index | input | 5 | Phase slot of the sample, 0 to 29 |
| cycle_sync | input | 1 | Period start, qualified by sample_valid |
| i_result | output | 37 | Trimmed in-phase bin sum |
| q_result | output | 37 | Trimmed quadrature bin sum |
| result_valid | output | 1 | One-clock result strobe |

## Verification
Two things can happen in the same cycle: the sync sample that closes a frame, and the write of that sample into the bank that has just been cleared. For the next 30 clocks, the reducer also reads one bank while the accumulator keeps writing the other. The bench streams frames back to back with no gap, so every frame's result is produced during the first period of the following frame. Each frame's result is compared against a model that clears its bins exactly at the closing sync. Full-scale positive and negative samples, and a third frame that reuses the first bank, expose any stale bin or any write that lands in the wrong bank.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  // number of demodulated channels (in-phase, quadrature)
  localparam int unsigned NCH = 2;
  localparam int unsigned CH_I = 0;
  localparam int unsigned CH_Q = 1;
  // bank selector for the ping-pong storage
  typedef logic bank_t;
endpackage

// File: rtl/sacc_frame_ctl.sv
module sacc_frame_ctl
  import sacc_pkg::*;
#(
  parameter int NSLOT = 30,
  parameter int NCYC  = 7,
  parameter int SLW   = $clog2(NSLOT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_valid,
  input  logic           cycle_sync,
  input  logic [SLW-1:0] slot_index,
  output logic           accept,
  output logic           swap,
  output logic           aligned,
  output bank_t          tgt_bank,
  output bank_t          rd_bank
);
  localparam int CW = $clog2(NCYC + 1);

  logic          aligned_q, aligned_d;
  bank_t         act_q, act_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic          sync_hit;

  assign sync_hit = sample_valid && cycle_sync;
  assign swap     = sync_hit && aligned_q && (cyc_q == CW'(NCYC));

  always_comb begin
    aligned_d = aligned_q;
    act_d     = act_q;
    cyc_d     = cyc_q;
    if (sync_hit) begin
      aligned_d = 1'b1;
      cyc_d     = (!aligned_q || swap) ? CW'(1) : cyc_q + CW'(1);
      act_d     = swap ? ~act_q : act_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      act_q     <= 1'b0;
      cyc_q     <= '0;
    end else if (sync_hit) begin
      aligned_q <= aligned_d;
      act_q     <= act_d;
      cyc_q     <= cyc_d;
    end
  end

  assign accept   = sample_valid && (aligned_q || cycle_sync) &&
                    ({1'b0, slot_index} < (SLW+1)'(NSLOT));
  assign tgt_bank = act_d;
  assign rd_bank  = ~act_q;
  assign aligned  = aligned_q;
endmodule

// File: rtl/sacc_bank.sv
module sacc_bank
  import sacc_pkg::*;
#(
  parameter int SW    = 24,
  parameter int AW    = 32,
  parameter int NSLOT = 30,
  parameter int SLW   = $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SLW-1:0]       wr_slot,
  input  logic [SW-1:0]        wr_data,
  input  bank_t                tgt_bank,
  input  logic                 clr,
  input  bank_t                rd_bank,
  input  logic [SLW-1:0]       rd_slot,
  output logic signed [AW-1:0] rd_data
);
  logic signed [AW-1:0] mem_q [2][NSLOT];
  logic signed [AW-1:0] mem_d [2][NSLOT];
  logic signed [AW-1:0] ext;

  assign ext = {{(AW-SW){wr_data[SW-1]}}, wr_data};

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < NSLOT; s++) begin
        logic hit;
        hit = wr_en && (wr_slot == SLW'(s)) && (tgt_bank == 1'(b));
        if (clr && (tgt_bank == 1'(b)))
          mem_d[b][s] = hit ? ext : '0;
        else if (hit)
          mem_d[b][s] = mem_q[b][s] + ext;
        else
          mem_d[b][s] = mem_q[b][s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NSLOT; s++)
          mem_q[b][s] <= '0;
    end else if (wr_en || clr) begin
      mem_q <= mem_d;
    end
  end

  assign rd_data = mem_q[rd_bank][rd_slot];
endmodule

// File: rtl/sacc_trim_reduce.sv
module sacc_trim_reduce #(
  parameter int AW    = 32,
  parameter int NSLOT = 30,
  parameter int SLW   = $clog2(NSLOT),
  parameter int RW    = AW + $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [AW-1:0] rd_data,
  output logic [SLW-1:0]       rd_slot,
  output logic signed [RW-1:0] result,
  output logic                 result_valid
);
  logic                 busy_q, busy_d;
  logic [SLW-1:0]       idx_q, idx_d;
  logic signed [RW-1:0] sum_q, sum_d, nsum, trim;
  logic signed [AW-1:0] mx_q, mx_d, nmx, mn_q, mn_d, nmn;
  logic signed [RW-1:0] res_q, res_d, v, mx_x, mn_x;
  logic                 vld_d, vld_q, first, last;

  assign first = (idx_q == '0);
  assign last  = (idx_q == SLW'(NSLOT-1));
  assign v     = {{(RW-AW){rd_data[AW-1]}}, rd_data};
  assign nsum  = first ? v : sum_q + v;
  assign nmx   = (first || rd_data > mx_q) ? rd_data : mx_q;
  assign nmn   = (first || rd_data < mn_q) ? rd_data : mn_q;
  assign mx_x  = {{(RW-AW){nmx[AW-1]}}, nmx};
  assign mn_x  = {{(RW-AW){nmn[AW-1]}}, nmn};
  assign trim  = nsum - mx_x - mn_x;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sum_d  = sum_q;
    mx_d   = mx_q;
    mn_d   = mn_q;
    res_d  = res_q;
    vld_d  = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      sum_d = nsum;
      mx_d  = nmx;
      mn_d  = nmn;
      idx_d = idx_q + SLW'(1);
      if (last) begin
        busy_d = 1'b0;
        res_d  = trim;
        vld_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sum_q  <= '0;
      mx_q   <= '0;
      mn_q   <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sum_q  <= sum_d;
      mx_q   <= mx_d;
      mn_q   <= mn_d;
      res_q  <= res_d;
      vld_q  <= vld_d;
    end
  end

  assign rd_slot      = idx_q;
  assign result       = res_q;
  assign result_valid = vld_q;
endmodule

// File: rtl/sync_slot_avg.sv
module sync_slot_avg
  import sacc_pkg::*;
#(
  parameter int SW    = 24,
  parameter int AW    = 32,
  parameter int NSLOT = 30,
  parameter int NCYC  = 7,
  localparam int SLW  = $clog2(NSLOT),
  localparam int RW   = AW + $clog2(NSLOT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic [SW-1:0]        samp_i,
  input  logic [SW-1:0]        samp_q,
  input  logic [SLW-1:0]       slot_index,
  input  logic                 cycle_sync,
  output logic signed [RW-1:0] i_result,
  output logic signed [RW-1:0] q_result,
  output logic                 result_valid
);
  logic  accept, swap, aligned;
  bank_t tgt_bank, rd_bank;

  logic [SW-1:0]        samp [NCH];
  logic signed [RW-1:0] res  [NCH];
  logic                 vld  [NCH];

  assign samp[CH_I] = samp_i;
  assign samp[CH_Q] = samp_q;

  sacc_frame_ctl #(.NSLOT(NSLOT), .NCYC(NCYC), .SLW(SLW)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .cycle_sync   (cycle_sync),
    .slot_index   (slot_index),
    .accept       (accept),
    .swap         (swap),
    .aligned      (aligned),
    .tgt_bank     (tgt_bank),
    .rd_bank      (rd_bank)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [AW-1:0] rd_data;
    logic [SLW-1:0]       rd_slot;

    sacc_bank #(.SW(SW), .AW(AW), .NSLOT(NSLOT), .SLW(SLW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept),
      .wr_slot  (slot_index),
      .wr_data  (samp[ch]),
      .tgt_bank (tgt_bank),
      .clr      (swap),
      .rd_bank  (rd_bank),
      .rd_slot  (rd_slot),
      .rd_data  (rd_data)
    );

    sacc_trim_reduce #(.AW(AW), .NSLOT(NSLOT), .SLW(SLW), .RW(RW)) u_red (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (swap),
      .rd_data      (rd_data),
      .rd_slot      (rd_slot),
      .result       (res[ch]),
      .result_valid (vld[ch])
    );
  end

  assign i_result     = res[CH_I];
  assign q_result     = res[CH_Q];
  assign result_valid = vld[CH_I] & vld[CH_Q];
endmodule

// File: rtl/sacc_chk.sv
module sacc_chk #(
  parameter int NSLOT = 30,
  parameter int RW    = 37
) (
  input logic          clk,
  input logic          rst_n,
  input logic          result_valid,
  input logic [RW-1:0] i_result,
  input logic [RW-1:0] q_result,
  input logic          swap,
  input logic          aligned
);
  localparam int LW = $clog2(NSLOT + 2) + 1;
  logic [LW-1:0] lat_q;

  // clocks elapsed since the last frame handoff, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_q <= '0;
    else if (swap)       lat_q <= '0;
    else if (lat_q != '1) lat_q <= lat_q + LW'(1);
  end

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(i_result) && $stable(q_result)));

  // R7
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (lat_q == LW'(NSLOT)));

  // R2
  no_result_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !result_valid);
endmodule

bind sync_slot_avg sacc_chk #(.NSLOT(NSLOT), .RW(RW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .result_valid (result_valid),
  .i_result     (i_result),
  .q_result     (q_result),
  .swap         (swap),
  .aligned      (aligned)
);

// File: tb/test_sync_slot_avg.sv
module test_sync_slot_avg;
  localparam int SW = 24, AW = 32, NSLOT = 30, NCYC = 7, SLW = 5, RW = 37;

  logic                 clk, rst_n, sample_valid, cycle_sync, result_valid;
  logic [SW-1:0]        samp_i, samp_q;
  logic [SLW-1:0]       slot_index;
  logic signed [RW-1:0] i_result, q_result;

  sync_slot_avg #(.SW(SW), .AW(AW), .NSLOT(NSLOT), .NCYC(NCYC)) i_sync_slot_avg (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .samp_i(samp_i),
    .samp_q(samp_q), .slot_index(slot_index), .cycle_sync(cycle_sync),
    .i_result(i_result), .q_result(q_result), .result_valid(result_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int clk_n = 0;
  always @(posedge clk) clk_n <= clk_n + 1;

  int errors = 0, checks = 0;
  bit done = 0;

  // result capture
  int     got_cnt = 0, wide_cnt = 0, got_at = 0;
  longint got_i = 0, got_q = 0;
  bit     prev_v = 0;
  always @(negedge clk) begin
    if (result_valid === 1'b1) begin
      got_cnt++;
      got_i  = i_result;
      got_q  = q_result;
      got_at = clk_n;
      if (prev_v) wide_cnt++;
    end
    prev_v = (result_valid === 1'b1);
  end

  // reference model
  bit     m_al = 0;
  int     m_cyc = 0;
  longint m_i [NSLOT];
  longint m_q [NSLOT];
  longint exp_i = 0, exp_q = 0;
  int     exp_at = 0, exp_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic close_model();
    longint si = 0, sq = 0, mxi, mni, mxq, mnq;
    mxi = m_i[0]; mni = m_i[0]; mxq = m_q[0]; mnq = m_q[0];
    for (int s = 0; s < NSLOT; s++) begin
      si += m_i[s]; sq += m_q[s];
      if (m_i[s] > mxi) mxi = m_i[s];
      if (m_i[s] < mni) mni = m_i[s];
      if (m_q[s] > mxq) mxq = m_q[s];
      if (m_q[s] < mnq) mnq = m_q[s];
    end
    exp_i  = si - mxi - mni;
    exp_q  = sq - mxq - mnq;
    exp_at = clk_n + 1;
    exp_cnt++;
    for (int s = 0; s < NSLOT; s++) begin m_i[s] = 0; m_q[s] = 0; end
  endtask

  task automatic send(input bit v, input bit s, input int slot, input int di, input int dq);
    @(negedge clk);
    sample_valid = v;
    cycle_sync   = s;
    slot_index   = slot[SLW-1:0];
    samp_i       = di[SW-1:0];
    samp_q       = dq[SW-1:0];
    if (v) begin
      if (s) begin
        if (!m_al) begin m_al = 1; m_cyc = 1; end
        else if (m_cyc == NCYC) begin close_model(); m_cyc = 1; end
        else m_cyc++;
      end
      if (m_al && slot < NSLOT) begin
        m_i[slot] += di;
        m_q[slot] += dq;
      end
    end
  endtask

  task automatic idle();
    send(0, 0, 0, 0, 0);
  endtask

  function automatic int pat_i(input int p, input int c, input int s);
    case (p)
      0:       return s * 1000 + c * 7 - 5000 + ((s == 3) ? 200000 : 0);
      1:       return (s % 2 == 1) ? 8388607 : -8388608;
      default: return s * s * 100 - c * 12345;
    endcase
  endfunction

  function automatic int pat_q(input int p, input int c, input int s);
    case (p)
      0:       return -(s * 333) + c;
      1:       return (s == 0) ? -8388608 : 8388607 - s * c;
      default: return 4000 - s * 77 * c;
    endcase
  endfunction

  task automatic run_frame(input int p);
    for (int c = 0; c < NCYC; c++) begin
      for (int s = 0; s < NSLOT; s++) begin
        send(1, s == 0, s, pat_i(p, c, s), pat_q(p, c, s));
        if (p == 0 && s % 7 == 3) idle();
        if (p == 2 && s == 10) begin
          send(1, 0, 31, 8000000, -8000000);   // R4 slot out of range
          send(1, 0, 30, -7000000, 7000000);   // R4 slot out of range
          send(0, 1, 0, 6000000, 6000000);     // R9 no valid
          send(0, 0, 5, -6000000, 1234567);    // R9 no valid
        end
      end
    end
  endtask

  task automatic check_frame(input string tag);
    chk(got_cnt == exp_cnt, {tag, " R7 strobe count"}, got_cnt, exp_cnt);
    chk(got_i == exp_i, {tag, " R3 R6 in-phase result"}, got_i, exp_i);
    chk(got_q == exp_q, {tag, " R3 R6 quadrature result"}, got_q, exp_q);
    chk(got_at - exp_at == NSLOT, {tag, " R7 latency"}, got_at - exp_at, NSLOT);
  endtask

  task automatic t_reset();
    rst_n = 0; sample_valid = 0; cycle_sync = 0; samp_i = '0; samp_q = '0; slot_index = '0;
    for (int s = 0; s < NSLOT; s++) begin m_i[s] = 0; m_q[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result_valid === 1'b0, "R1 strobe in reset", result_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(result_valid === 1'b0, "R1 strobe after reset", result_valid, 0);
    chk(i_result === '0 && q_result === '0, "R1 results after reset", i_result, 0);
  endtask

  task automatic t_presync();
    // R2: accepted-looking samples before alignment must be dropped
    for (int k = 0; k < 40; k++) send(1, 0, k % NSLOT, 1000000 + k, -1000000 - k);
    send(0, 1, 0, 2000000, 2000000);  // R9: sync without valid does not align
    idle();
    chk(result_valid === 1'b0, "R2 no strobe before alignment", result_valid, 0);
  endtask

  task automatic t_stream();
    run_frame(0);                       // frame A (after pre-sync garbage)
    run_frame(1);                       // frame B, extremes; A reduced meanwhile
    check_frame("frame A R2 R8");
    run_frame(2);                       // frame C reuses first bank
    check_frame("frame B R5 R8");
    send(1, 1, 0, 5, -5);               // closing sync for C
    repeat (NSLOT + 5) idle();
    check_frame("frame C R4 R5 R9");
    chk(wide_cnt == 0, "R7 single-clock strobe", wide_cnt, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset();
    t_presync();
    t_stream();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", clk_n, 0);
      summary();
      $finish;
    end
  end
endmodule